// File: doc/BRIEF.md
# Serial Transceiver with Three-Point Noise Detection

This block is a full-duplex asynchronous serial port. A divider turns the system clock into a tick at sixteen times the bit rate, and both directions time their bits from that tick. The nominal line rate is 57600 bit/s. A byte offered on the transmit handshake goes out as a framed character: one low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Received characters are returned on a valid pulse, together with their error flags.

The receiver takes three samples of every bit, start and stop included, at oversampling ticks 7, 8 and 9 of that bit. The bit takes the majority value of those samples. Whenever the three samples of any bit in a character disagree, the receiver raises a noise error for that character. The byte is still delivered, built from the majority values. Framing and parity errors are reported next to it. Parity enable and odd/even selection are static configuration inputs, and so is the divider count.

Top module: `uartn_top`

## Requirements
- R1: The oversampling tick fires once every `baud_div` system clocks (a count of 0 behaves as 1). Every transmitted bit lasts exactly 16 ticks, so `tx_ready` returns high exactly (bits per frame) × 16 × `baud_div` clocks after the start bit begins.
- R2: A transmitted frame is a start bit at 0, then the data bits LSB first, then the parity bit when enabled, then a stop bit at 1. `txd` is 1 whenever no frame is being sent.
- R3: `tx_ready` is high when the transmitter is idle. A byte is taken on a clock where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low from the next clock until the stop bit has completed.
- R4: With `par_en`=1 and `par_odd`=0 the parity bit makes the count of ones in data plus parity even. With `par_odd`=1 that count is odd. With `par_en`=0 no parity bit is sent or expected.
- R5: The receiver reads each bit at oversampling ticks 7, 8 and 9, counted from the tick at which it detected the start edge, and takes the majority value. A single disturbed sample does not change the received data.
- R6: If the three samples of any bit of a character are not all equal, `rx_noise_err` is 1 for that character, and the majority-built byte is still delivered.
- R7: A stop bit whose majority value is 0 sets `rx_frame_err` for that character.
- R8: With parity enabled, a received parity bit that does not match the data under the selected sense sets `rx_par_err`. With parity disabled, `rx_par_err` is 0.
- R9: A low pulse on an idle line whose start-bit majority value is 1 is discarded and produces no `rx_valid`. A correct frame that follows it is received normally.
- R10: `rx_valid` is a single-clock pulse, raised once per accepted character. `rx_data` and the three error flags are valid in that cycle.
- R11: After reset, `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_div | input | DIV_W | System clocks per oversampling tick |
| par_en | input | 1 | 1 = parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Byte to transmit |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-clock pulse, received character ready |
| rx_data | output | DATA_W | Received byte (majority values) |
| rx_frame_err | output | 1 | Stop bit was read as 0 |
| rx_par_err | output | 1 | Parity mismatch |
| rx_noise_err | output | 1 | Some bit had disagreeing samples |

## Verification
The assertions check four properties on every cycle. `txd` changes only in the cycle after an oversampling tick. The line is high while the transmitter reports idle. `tx_ready` drops right after a handshake. `rx_valid` never lasts two cycles. Everything that depends on the contents of a character can only be shown by the bench's scenarios: frame layout, parity sense, majority voting, the noise, framing and parity flags, and the rejection of false starts. The bench drives frames with flipped samples, bad stop and parity bits and short glitches, and compares each delivered byte and flag with values worked out from the requirements.

// File: rtl/uartn_pkg.sv
// Shared constants and types for the serial transceiver.
// Assumes 16x oversampling and a three-point centre sample window.
package uartn_pkg;
    localparam int OVS      = 16;   // ticks per bit
    localparam int SMP_LO   = 7;    // first centre sample tick
    localparam int SMP_MID  = 8;    // second centre sample tick
    localparam int SMP_HI   = 9;    // third sample tick, decision point
    localparam int PH_W     = $clog2(OVS);

    typedef enum logic {RX_IDLE, RX_RUN} rx_state_t;
endpackage

// File: rtl/uartn_baud.sv
// Oversampling tick generator: one-clock pulse every div system clocks.
// Assumes div is static while traffic is in flight; div of 0 acts as 1.
module uartn_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Terminal count for the current divider setting.
    always_comb lim = (div == '0) ? '0 : div - 1'b1;

    assign tick = (cnt >= lim);

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uartn_tx.sv
// Transmitter: frames a byte as start, data LSB first, optional parity, stop.
// Each bit is held for OVS ticks; txd changes only after a tick.
// Assumes par_en/par_odd are stable when a byte is accepted.
module uartn_tx
    import uartn_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              txd
);
    localparam int FW   = DATA_W + 3;
    localparam int NL_W = $clog2(FW + 1);

    logic            busy;
    logic [FW-1:0]   sh;
    logic [FW-1:0]   frame;
    logic [NL_W-1:0] nleft;
    logic [NL_W-1:0] nbits;
    logic [PH_W-1:0] tcnt;
    logic            pbit;

    // Build the outgoing frame and its length from the offered byte.
    always_comb begin
        pbit  = (^data) ^ par_odd;
        frame = par_en ? {1'b1, pbit, data, 1'b0} : {2'b11, data, 1'b0};
        nbits = par_en ? NL_W'(FW) : NL_W'(FW - 1);
    end

    assign ready = !busy;

    // Accept a byte, then shift one bit out every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sh    <= '1;
            nleft <= '0;
            tcnt  <= '0;
            txd   <= 1'b1;
        end else if (!busy) begin
            if (valid) begin
                busy  <= 1'b1;
                sh    <= frame;
                nleft <= nbits;
                tcnt  <= '0;
            end
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == '0) begin
                if (nleft == '0) begin
                    busy <= 1'b0;
                end else begin
                    txd   <= sh[0];
                    sh    <= {1'b1, sh[FW-1:1]};
                    nleft <= nleft - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uartn_rx.sv
// Receiver: detects a start edge on a tick and reads each bit at ticks 7, 8, 9.
// The majority value is kept, and any disagreement marks the character noisy.
// Assumes rxd is asynchronous (two-flop synchroniser) and config is static.
module uartn_rx
    import uartn_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              frame_err,
    output logic              par_err,
    output logic              noise_err
);
    localparam int BI_W = $clog2(DATA_W + 3);

    rx_state_t         st;
    logic              s1, s2;
    logic [PH_W-1:0]   phase;
    logic [BI_W-1:0]   bidx;
    logic              smp_a, smp_b;
    logic              maj, dis;
    logic [DATA_W-1:0] dsh;
    logic              pbit, pe_q, po_q, nacc;
    logic [BI_W-1:0]   stop_idx;

    // Vote on the two held samples and the live third one.
    always_comb begin
        maj      = (smp_a & smp_b) | (smp_a & s2) | (smp_b & s2);
        dis      = !((smp_a == smp_b) && (smp_b == s2));
        stop_idx = pe_q ? BI_W'(DATA_W + 2) : BI_W'(DATA_W + 1);
    end

    // Two-flop synchroniser for the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    // Frame sequencer: start detection, centre sampling, result delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= RX_IDLE;
            phase     <= '0;
            bidx      <= '0;
            smp_a     <= 1'b1;
            smp_b     <= 1'b1;
            dsh       <= '0;
            pbit      <= 1'b0;
            pe_q      <= 1'b0;
            po_q      <= 1'b0;
            nacc      <= 1'b0;
            valid     <= 1'b0;
            data      <= '0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            noise_err <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (tick) begin
                if (st == RX_IDLE) begin
                    if (!s2) begin
                        st    <= RX_RUN;
                        phase <= PH_W'(1);
                        bidx  <= '0;
                        pe_q  <= par_en;
                        po_q  <= par_odd;
                        nacc  <= 1'b0;
                    end
                end else begin
                    phase <= phase + 1'b1;
                    if (phase == PH_W'(OVS - 1)) bidx <= bidx + 1'b1;
                    if (phase == PH_W'(SMP_LO))  smp_a <= s2;
                    if (phase == PH_W'(SMP_MID)) smp_b <= s2;
                    if (phase == PH_W'(SMP_HI)) begin
                        if (bidx == '0) begin
                            if (maj) st <= RX_IDLE;
                            nacc <= dis;
                        end else if (bidx <= BI_W'(DATA_W)) begin
                            dsh  <= {maj, dsh[DATA_W-1:1]};
                            nacc <= nacc | dis;
                        end else if (bidx == stop_idx) begin
                            st        <= RX_IDLE;
                            valid     <= 1'b1;
                            data      <= dsh;
                            frame_err <= !maj;
                            par_err   <= pe_q && (pbit != ((^dsh) ^ po_q));
                            noise_err <= nacc | dis;
                        end else begin
                            pbit <= maj;
                            nacc <= nacc | dis;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uartn_top.sv
// Full-duplex serial transceiver top: shared tick divider, transmitter, receiver.
// Assumes configuration inputs change only while both directions are idle.
module uartn_top #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_frame_err,
    output logic              rx_par_err,
    output logic              rx_noise_err
);
    logic os_tick;

    uartn_baud #(.DIV_W(DIV_W)) u_baud (
        .clk (clk), .rst_n (rst_n), .div (baud_div), .tick (os_tick)
    );

    uartn_tx #(.DATA_W(DATA_W)) u_tx (
        .clk (clk), .rst_n (rst_n), .tick (os_tick),
        .par_en (par_en), .par_odd (par_odd),
        .valid (tx_valid), .data (tx_data), .ready (tx_ready), .txd (txd)
    );

    uartn_rx #(.DATA_W(DATA_W)) u_rx (
        .clk (clk), .rst_n (rst_n), .tick (os_tick),
        .par_en (par_en), .par_odd (par_odd), .rxd (rxd),
        .valid (rx_valid), .data (rx_data), .frame_err (rx_frame_err),
        .par_err (rx_par_err), .noise_err (rx_noise_err)
    );
endmodule

// File: rtl/uartn_chk.sv
// Property checker for uartn_top, attached by bind below.
// Assumes it sees the top's ports and its internal oversampling tick.
module uartn_chk (
    input logic clk,
    input logic rst_n,
    input logic os_tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic rx_valid
);
    AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(os_tick)); // R1

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd); // R2

    AST_TX_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready); // R3

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R10
endmodule

bind uartn_top uartn_chk u_chk (
    .clk (clk), .rst_n (rst_n), .os_tick (os_tick), .tx_valid (tx_valid),
    .tx_ready (tx_ready), .txd (txd), .rx_valid (rx_valid)
);

// File: tb/uartn_top_tb.sv
// Bench: behavioural line model drives rxd and decodes txd; results compared per clock.
module uartn_top_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   baud_div = 16'd4;
    logic          par_en = 1'b1, par_odd = 1'b0;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_ready, txd, rxd = 1'b1;
    logic          rx_valid, rx_frame_err, rx_par_err, rx_noise_err;
    logic [DW-1:0] rx_data;

    int tests = 0, fails = 0;
    bit tx_active = 0;
    bit finished = 0;
    int exp_data[$];
    int exp_flags[$];   // {noise, parity, frame}

    always #2 clk = ~clk;

    uartn_top u_dut (
        .clk (clk), .rst_n (rst_n), .baud_div (baud_div), .par_en (par_en),
        .par_odd (par_odd), .tx_valid (tx_valid), .tx_data (tx_data),
        .tx_ready (tx_ready), .txd (txd), .rxd (rxd), .rx_valid (rx_valid),
        .rx_data (rx_data), .rx_frame_err (rx_frame_err),
        .rx_par_err (rx_par_err), .rx_noise_err (rx_noise_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison: idle line level, and each receive result against the model queue.
    always @(negedge clk) begin
        if (rst_n && !tx_active && txd !== 1'b1) begin
            fails++;
            $display("FAIL R2 actual=%0b expected=1 (idle line)", txd);
        end
        if (rst_n && rx_valid) begin
            if (exp_data.size() == 0) begin
                check(0, "R9/R10 unexpected rx_valid", rx_data, 0);
            end else begin
                int ed, ef;
                ed = exp_data.pop_front();
                ef = exp_flags.pop_front();
                check(rx_data == ed[DW-1:0], "R5 rx_data", rx_data, ed);
                check({rx_noise_err, rx_par_err, rx_frame_err} == ef[2:0],
                      "R6/R7/R8 rx flags", {rx_noise_err, rx_par_err, rx_frame_err}, ef);
            end
        end
    end

    // Send one byte through the transmit handshake and decode it from txd.
    task automatic tx_send(input logic [DW-1:0] b);
        int bitclk, nb, cnt;
        logic [11:0] fr;
        bitclk = 16 * int'(baud_div);
        nb = par_en ? 11 : 10;
        fr = par_en ? {1'b1, (^b) ^ par_odd, b, 1'b0} : {2'b11, b, 1'b0};
        tx_active = 1;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = b;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R3 ready low after accept", tx_ready, 0);
        cnt = 0;
        while (txd && cnt < 64 * bitclk) begin @(negedge clk); cnt++; end
        repeat (bitclk / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            check(txd == fr[i], $sformatf("R2/R4 tx bit %0d", i), txd, fr[i]);
            if (i < nb - 1) repeat (bitclk) @(negedge clk);
        end
        cnt = bitclk / 2 + (nb - 1) * bitclk;
        while (!tx_ready && cnt < 64 * bitclk) begin @(negedge clk); cnt++; end
        check(cnt == nb * bitclk, "R1 frame length", cnt, nb * bitclk);
        tx_active = 0;
    endtask

    // Drive one character on rxd; noise_bit flips a 4-clock window holding one sample.
    task automatic rx_send(input logic [DW-1:0] b, input bit stop_v, input bit bad_par,
                           input int noise_bit);
        int bitclk, nb;
        logic [11:0] fr;
        bit p;
        bitclk = 16 * int'(baud_div);
        nb = par_en ? 11 : 10;
        p = (^b) ^ par_odd ^ bad_par;
        fr = par_en ? {stop_v, p, b, 1'b0} : {1'b1, stop_v, b, 1'b0};
        exp_data.push_back(int'(b));
        exp_flags.push_back({29'd0, noise_bit >= 0, par_en && bad_par, !stop_v});
        for (int i = 0; i < nb; i++)
            for (int c = 0; c < bitclk; c++) begin
                @(negedge clk);
                rxd = (i == noise_bit && c >= 34 && c <= 37) ? ~fr[i] : fr[i];
            end
        @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bitclk) @(negedge clk);
        check(exp_data.size() == 0, "R10 character delivered", exp_data.size(), 0);
        exp_data.delete();
        exp_flags.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R11 txd reset", txd, 1);
        check(tx_ready == 1'b1, "R11 tx_ready reset", tx_ready, 1);
        check(rx_valid == 1'b0, "R11 rx_valid reset", rx_valid, 0);

        // R2 R4: even parity, then odd, then no parity
        tx_send(8'hA5);
        par_odd = 1'b1;
        tx_send(8'h3C);
        par_en = 1'b0;
        tx_send(8'h81);
        // R1: a different divider
        baud_div = 16'd6;
        par_en = 1'b1;
        par_odd = 1'b0;
        tx_send(8'h5E);
        baud_div = 16'd4;

        // R5: clean receive, both parity senses
        rx_send(8'h96, 1'b1, 1'b0, -1);
        par_odd = 1'b1;
        rx_send(8'h0F, 1'b1, 1'b0, -1);
        // R6: single-sample noise on data, start and stop bits
        rx_send(8'hC3, 1'b1, 1'b0, 3);
        rx_send(8'h5A, 1'b1, 1'b0, 0);
        rx_send(8'h77, 1'b1, 1'b0, 10);
        // R8: parity mismatch, and ignored when parity is off
        rx_send(8'h12, 1'b1, 1'b1, -1);
        par_en = 1'b0;
        rx_send(8'hE4, 1'b1, 1'b1, -1);
        // R7: stop bit low
        par_en = 1'b1;
        rx_send(8'h6B, 1'b0, 1'b0, -1);

        // R9: short glitch gives no character, next frame received normally
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (16 * 4 * 12) @(negedge clk);
        rx_send(8'hB2, 1'b1, 1'b0, -1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule